// File: doc/BRIEF.md
# Flash erase command decoder

This block sits beside a parallel flash-style write bus. It watches the address, data and active-low write strobe, and it recognises the two six-write erase command sequences. Each sequence is two unlock writes, a setup write, two more unlock writes and a final command write. A final chip-erase command fires the erase engine at once, with every sector selected.

A final sector-erase command instead opens an accumulation window. While the window is open, further sector-erase writes add their sectors to a selection mask. The timeout restarts on every strobe edge, and it stays frozen while the strobe is held low. When the window runs out, the block pulses a start strobe for one cycle and presents the gathered mask to the erase engine.

Any command inside the window other than another sector erase or an erase suspend throws the sequence away. The decoder then returns to read mode without starting anything. A status output reports whether the window is open. All timing is counted in clock cycles.

Top module: `flash_erase_seq`

## Requirements
- R1: Out of reset, the start strobe and window status are low and the erase mask output is all zeros.
- R2: The six writes (address/data) 555h/AAh, 2AAh/55h, 555h/80h, 555h/AAh, 2AAh/55h, 555h/10h cause the following effects on the clock edge that sees the strobe of the sixth write return high. The start strobe pulses. The mask becomes all 19 ones. The window stays closed. Only the low 11 address bits are compared for unlock, setup and chip-erase writes.
- R3: A write whose address or data does not match the expected pair at any step returns the decoder to idle. No window opens and nothing starts, and a later complete sequence is accepted normally.
- R4: After the five prefix writes, a sixth write of data 30h at any address opens the window on the edge that sees its strobe rise.
- R5: With no further bus activity, the start strobe rises exactly TIMEOUT clock edges after the rising strobe edge of the last accepted window write. The window status falls on that same edge.
- R6: The sector of a write is the address bits from bit 11 upward, read as a number and clamped to 18. The address is taken on the falling strobe edge; the data is taken on the rising edge.
- R7: Each 30h write inside the window sets its sector's mask bit, in any order, with repeats harmless. Each such write restarts the timeout.
- R8: Inside the window the timeout is held while the strobe is low and restarts on a falling strobe edge. A falling edge that lands on the very edge where the timeout would expire keeps the window open.
- R9: A B0h write inside the window is accepted. It changes no mask bit, keeps the window open and restarts the timeout.
- R10: Any other data written inside the window closes it on that write's rising edge. No start follows, and the mask output keeps its previous value.
- R11: The start strobe lasts exactly one cycle. The mask output changes only together with a start strobe and holds its value in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | ADDR_W (16) | Write bus address |
| busData | input | 8 | Write bus data |
| busWeN | input | 1 | Active-low write strobe, synchronous to clk |
| windowOpen | output | 1 | High while the sector accumulation window is open |
| eraseStart | output | 1 | One-cycle start pulse to the erase engine |
| eraseMask | output | N_SECT (19) | Selected sectors, valid from the start pulse on |

## Verification
The delicate overlap is a falling strobe edge in the window arriving on the exact clock edge where the timeout counter would expire. The bench gets there by counting TIMEOUT-1 cycles after the last rising edge and pulling the strobe low half a cycle before the expiry edge. It then expects the window to stay open and no start to appear, and it expects expiry one full TIMEOUT after the later rise. A second overlap pairs a window write with a changing address between strobe edges, to confirm that the sector comes from the falling-edge address. Random runs mix queued sectors, suspend writes and aborts against a bench mask model.

// File: rtl/flash_erase_pkg.sv
package flash_erase_pkg;

  localparam int UNL_W = 11;

  localparam logic [7:0] CODE_UNLOCK_A = 8'hAA;
  localparam logic [7:0] CODE_UNLOCK_B = 8'h55;
  localparam logic [7:0] CODE_SETUP    = 8'h80;
  localparam logic [7:0] CODE_CHIP     = 8'h10;
  localparam logic [7:0] CODE_SECTOR   = 8'h30;
  localparam logic [7:0] CODE_SUSPEND  = 8'hB0;

  localparam logic [UNL_W-1:0] ADR_FIRST  = 11'h555;
  localparam logic [UNL_W-1:0] ADR_SECOND = 11'h2AA;

  typedef enum logic [2:0] {
    S_IDLE, S_UNL1, S_UNL2, S_SETUP, S_UNL3, S_UNL4, S_WINDOW
  } seqState_t;

  // bus events decoded by the datapath for the control
  typedef struct packed {
    logic       weFall;
    logic       weRise;
    logic       weLow;
    logic       atFirst;
    logic       atSecond;
    logic [7:0] code;
  } busEvt_t;

  // strobes from control to datapath
  typedef struct packed {
    logic clrAcc;
    logic addSect;
    logic fireSector;
    logic fireChip;
  } dpCtrl_t;

endpackage

// File: rtl/flash_erase_dp.sv
module flash_erase_dp
  import flash_erase_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int SECT_LSB = 11,
  parameter int N_SECT   = 19
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [7:0]        busData,
  input  logic              busWeN,
  input  dpCtrl_t           ctrl,
  output busEvt_t           evt,
  output logic [N_SECT-1:0] eraseMask
);

  localparam int IDX_W = ADDR_W - SECT_LSB;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_SECT - 1);

  logic              weNq;
  logic [ADDR_W-1:0] addrLatch;
  logic [IDX_W-1:0]  rawIdx;
  logic [IDX_W-1:0]  sectIdx;
  logic [N_SECT-1:0] sectHit;
  logic [N_SECT-1:0] accMask;

  // strobe edge detection and falling-edge address capture
  always_ff @(posedge clk) begin
    if (!rstN) begin
      weNq      <= 1'b1;
      addrLatch <= '0;
    end else begin
      weNq <= busWeN;
      if (weNq && !busWeN) addrLatch <= busAddr;
    end
  end

  always_comb begin
    evt.weFall   = weNq & ~busWeN;
    evt.weRise   = ~weNq & busWeN;
    evt.weLow    = ~busWeN;
    evt.atFirst  = (addrLatch[UNL_W-1:0] == ADR_FIRST);
    evt.atSecond = (addrLatch[UNL_W-1:0] == ADR_SECOND);
    evt.code     = busData;
  end

  // sector index with clamp to the last sector
  assign rawIdx  = addrLatch[ADDR_W-1:SECT_LSB];
  assign sectIdx = (rawIdx >= LAST_IDX) ? LAST_IDX : rawIdx;

  for (genvar i = 0; i < N_SECT; i++) begin : g_hit
    assign sectHit[i] = (sectIdx == IDX_W'(i));
  end

  // accumulation and output mask
  always_ff @(posedge clk) begin
    if (!rstN) begin
      accMask   <= '0;
      eraseMask <= '0;
    end else begin
      if (ctrl.addSect)     accMask <= (ctrl.clrAcc ? '0 : accMask) | sectHit;
      else if (ctrl.clrAcc) accMask <= '0;
      if (ctrl.fireChip)        eraseMask <= '1;
      else if (ctrl.fireSector) eraseMask <= accMask;
    end
  end

  a_r7_acc_keeps_bits: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.addSect && !ctrl.clrAcc) |=> ((accMask & $past(accMask)) == $past(accMask)));

  a_r2_chip_all_ones: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.fireChip |=> (eraseMask == {N_SECT{1'b1}}));

  a_r6_one_hot_hit: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(sectHit) && (sectHit != '0));

endmodule

// File: rtl/flash_erase_ctrl.sv
module flash_erase_ctrl
  import flash_erase_pkg::*;
#(
  parameter int TIMEOUT = 10000
) (
  input  logic    clk,
  input  logic    rstN,
  input  busEvt_t evt,
  output dpCtrl_t ctrl,
  output logic    windowOpen,
  output logic    eraseStart
);

  localparam int CNT_W = (TIMEOUT > 2) ? $clog2(TIMEOUT) : 1;
  localparam logic [CNT_W-1:0] RELOAD = CNT_W'(TIMEOUT - 1);

  seqState_t        state, nxt;
  logic [CNT_W-1:0] cnt;

  always_comb begin
    nxt  = state;
    ctrl = '0;
    case (state)
      S_IDLE:
        if (evt.weRise && evt.atFirst && evt.code == CODE_UNLOCK_A) nxt = S_UNL1;
      S_UNL1:
        if (evt.weRise)
          nxt = (evt.atSecond && evt.code == CODE_UNLOCK_B) ? S_UNL2 : S_IDLE;
      S_UNL2:
        if (evt.weRise)
          nxt = (evt.atFirst && evt.code == CODE_SETUP) ? S_SETUP : S_IDLE;
      S_SETUP:
        if (evt.weRise)
          nxt = (evt.atFirst && evt.code == CODE_UNLOCK_A) ? S_UNL3 : S_IDLE;
      S_UNL3:
        if (evt.weRise)
          nxt = (evt.atSecond && evt.code == CODE_UNLOCK_B) ? S_UNL4 : S_IDLE;
      S_UNL4:
        if (evt.weRise) begin
          if (evt.code == CODE_SECTOR) begin
            nxt          = S_WINDOW;
            ctrl.addSect = 1'b1;
            ctrl.clrAcc  = 1'b1;
          end else begin
            nxt           = S_IDLE;
            ctrl.fireChip = evt.atFirst && (evt.code == CODE_CHIP);
          end
        end
      S_WINDOW:
        if (evt.weRise) begin
          if (evt.code == CODE_SECTOR) begin
            ctrl.addSect = 1'b1;
          end else if (evt.code != CODE_SUSPEND) begin
            nxt         = S_IDLE;
            ctrl.clrAcc = 1'b1;
          end
        end else if (!evt.weLow && cnt == '0) begin
          nxt             = S_IDLE;
          ctrl.fireSector = 1'b1;
          ctrl.clrAcc     = 1'b1;
        end
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= S_IDLE;
      cnt        <= '0;
      eraseStart <= 1'b0;
    end else begin
      state      <= nxt;
      eraseStart <= ctrl.fireChip | ctrl.fireSector;
      if (nxt == S_WINDOW && (state != S_WINDOW || evt.weLow || evt.weRise))
        cnt <= RELOAD;
      else if (state == S_WINDOW && cnt != '0)
        cnt <= cnt - 1'b1;
    end
  end

  assign windowOpen = (state == S_WINDOW);

  a_r11_start_single: assert property (@(posedge clk) disable iff (!rstN)
    eraseStart |=> !eraseStart);

  a_r5_start_window_closed: assert property (@(posedge clk) disable iff (!rstN)
    eraseStart |-> !windowOpen);

  a_r10_abort_closes: assert property (@(posedge clk) disable iff (!rstN)
    (windowOpen && evt.weRise && evt.code != CODE_SECTOR && evt.code != CODE_SUSPEND)
      |=> (!windowOpen && !eraseStart));

  a_r8_fall_keeps_open: assert property (@(posedge clk) disable iff (!rstN)
    (windowOpen && evt.weFall) |=> windowOpen);

  a_r5_cnt_bound: assert property (@(posedge clk) disable iff (!rstN)
    windowOpen |-> (cnt <= RELOAD));

endmodule

// File: rtl/flash_erase_seq.sv
module flash_erase_seq
  import flash_erase_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int SECT_LSB = 11,
  parameter int N_SECT   = 19,
  parameter int TIMEOUT  = 10000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [7:0]        busData,
  input  logic              busWeN,
  output logic              windowOpen,
  output logic              eraseStart,
  output logic [N_SECT-1:0] eraseMask
);

  busEvt_t evt;
  dpCtrl_t ctrl;

  flash_erase_dp #(
    .ADDR_W  (ADDR_W),
    .SECT_LSB(SECT_LSB),
    .N_SECT  (N_SECT)
  ) i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .busAddr  (busAddr),
    .busData  (busData),
    .busWeN   (busWeN),
    .ctrl     (ctrl),
    .evt      (evt),
    .eraseMask(eraseMask)
  );

  flash_erase_ctrl #(
    .TIMEOUT(TIMEOUT)
  ) i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .evt       (evt),
    .ctrl      (ctrl),
    .windowOpen(windowOpen),
    .eraseStart(eraseStart)
  );

  a_r11_mask_hold: assert property (@(posedge clk) disable iff (!rstN)
    !eraseStart |-> $stable(eraseMask));

  a_r11_start_mask_nonzero: assert property (@(posedge clk) disable iff (!rstN)
    eraseStart |-> (eraseMask != '0));

endmodule

// File: tb/test_flash_erase_seq.sv
`timescale 1ns/100ps
module test_flash_erase_seq;

  localparam int AW = 16;
  localparam int NS = 19;
  localparam int TO = 20;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [AW-1:0] busAddr = '0;
  logic [7:0]    busData = '0;
  logic          busWeN = 1'b1;
  logic          windowOpen, eraseStart;
  logic [NS-1:0] eraseMask;

  int nCheck = 0;
  int nFail  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  flash_erase_seq #(.ADDR_W(AW), .SECT_LSB(11), .N_SECT(NS), .TIMEOUT(TO)) i_flash_erase_seq (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busData(busData), .busWeN(busWeN),
    .windowOpen(windowOpen), .eraseStart(eraseStart), .eraseMask(eraseMask)
  );

  function automatic int sectOf(logic [AW-1:0] a);
    int s = int'(a >> 11);
    return (s > NS - 1) ? NS - 1 : s;
  endfunction

  function automatic logic [NS-1:0] bitOf(logic [AW-1:0] a);
    return NS'(1) << sectOf(a);
  endfunction

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    nCheck++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one bus write: strobe low with the address, data held across the rise
  task automatic wr(logic [AW-1:0] a, logic [7:0] d);
    @(negedge clk); busAddr = a; busData = d; busWeN = 1'b0;
    @(negedge clk);
    @(negedge clk); busWeN = 1'b1;
    @(negedge clk);
  endtask

  // write whose address changes between the strobe edges
  task automatic wrSplit(logic [AW-1:0] aFall, logic [AW-1:0] aRise, logic [7:0] d);
    @(negedge clk); busAddr = aFall; busData = d; busWeN = 1'b0;
    @(negedge clk); busAddr = aRise;
    @(negedge clk); busWeN = 1'b1;
    @(negedge clk);
  endtask

  task automatic prefix();
    wr(16'h0555, 8'hAA); wr(16'h02AA, 8'h55); wr(16'h0555, 8'h80);
    wr(16'h0555, 8'hAA); wr(16'h02AA, 8'h55);
  endtask

  // n cycles with no start expected; one check
  task automatic quiet(int n, string req);
    bit seen = 1'b0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (eraseStart) seen = 1'b1;
    end
    check(!seen, req, 32'(seen), 32'd0);
  endtask

  // after the last accepted window write: expiry exactly TO edges later
  task automatic expectExpiry(logic [NS-1:0] expMask, string req);
    bit early = 1'b0;
    for (int i = 0; i < TO - 1; i++) begin
      if (eraseStart || !windowOpen) early = 1'b1;
      @(negedge clk);
    end
    check(!early && windowOpen, req, 32'(early), 32'd0);
    @(negedge clk);
    check(eraseStart && !windowOpen, req, {30'd0, eraseStart, windowOpen}, 32'd2);
    check(eraseMask == expMask, req, 32'(eraseMask), 32'(expMask));
    @(negedge clk);
    check(!eraseStart && eraseMask == expMask, "R11", {31'd0, eraseStart}, 32'd0);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      nFail++; nCheck++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", nCheck - nFail, nCheck);
      $finish;
    end
  end

  initial begin
    logic [NS-1:0] expM;
    logic [NS-1:0] lastMask;
    int seedDummy;
    seedDummy = $urandom(32'd4242);
    repeat (4) @(negedge clk);
    // R1 reset state
    check(!eraseStart && !windowOpen && eraseMask == '0, "R1",
          {12'd0, eraseMask, eraseStart}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);

    // R2 chip erase
    prefix(); wr(16'h0555, 8'h10);
    check(eraseStart && !windowOpen, "R2", {30'd0, eraseStart, windowOpen}, 32'd2);
    check(eraseMask == {NS{1'b1}}, "R2", 32'(eraseMask), 32'h7FFFF);
    @(negedge clk);
    check(!eraseStart && eraseMask == {NS{1'b1}}, "R11", {31'd0, eraseStart}, 32'd0);

    // R2 upper address bits ignored for unlock compares
    wr(16'hF555, 8'hAA); wr(16'h3AAA, 8'h55); wr(16'h8555, 8'h80);
    wr(16'h0555, 8'hAA); wr(16'h02AA, 8'h55); wr(16'hC555, 8'h10);
    check(eraseStart, "R2", 32'(eraseStart), 32'd1);

    // R3 chip erase with wrong final address
    prefix(); wr(16'h0123, 8'h10);
    check(!eraseStart && !windowOpen, "R3", {30'd0, eraseStart, windowOpen}, 32'd0);
    // R3 bad setup data then rest of sequence: nothing happens
    wr(16'h0555, 8'hAA); wr(16'h02AA, 8'h55); wr(16'h0555, 8'h81);
    wr(16'h0555, 8'hAA); wr(16'h02AA, 8'h55); wr(16'h0555, 8'h30);
    check(!windowOpen, "R3", 32'(windowOpen), 32'd0);
    // R3 wrong unlock address at step 2
    wr(16'h0555, 8'hAA); wr(16'h02AB, 8'h55); wr(16'h0555, 8'h80);
    wr(16'h0555, 8'hAA); wr(16'h02AA, 8'h55); wr(16'h0555, 8'h10);
    quiet(3, "R3");

    // R4 R5 single sector
    prefix(); wr(16'h1800, 8'h30);
    check(windowOpen, "R4", 32'(windowOpen), 32'd1);
    expectExpiry(NS'(1) << 3, "R5");

    // R6 R7 multi sector any order, clamp, repeat
    prefix(); wr(16'hF800, 8'h30);
    wr(16'h0004, 8'h30); wr(16'h3801, 8'h30); wr(16'h3FFF, 8'h30);
    check(windowOpen && !eraseStart, "R7", 32'(windowOpen), 32'd1);
    expectExpiry((NS'(1) << 18) | NS'(1) | (NS'(1) << 7), "R7");

    // R6 address from falling edge
    prefix(); wrSplit(16'h2800, 16'h4800, 8'h30);
    expectExpiry(NS'(1) << 5, "R6");

    // R9 suspend code inside the window
    prefix(); wr(16'h5000, 8'h30); wr(16'h7800, 8'hB0);
    check(windowOpen, "R9", 32'(windowOpen), 32'd1);
    expectExpiry(NS'(1) << 10, "R9");

    // R10 abort keeps old mask, no start
    lastMask = eraseMask;
    prefix(); wr(16'h0800, 8'h30); wr(16'h0800, 8'hF0);
    check(!windowOpen, "R10", 32'(windowOpen), 32'd0);
    quiet(TO + 5, "R10");
    check(eraseMask == lastMask, "R10", 32'(eraseMask), 32'(lastMask));

    // R8 strobe held low freezes the timer
    prefix(); wr(16'h6000, 8'h30);
    @(negedge clk); busWeN = 1'b0; busAddr = 16'h6800; busData = 8'h30;
    repeat (3 * TO) @(negedge clk);
    check(windowOpen && !eraseStart, "R8", 32'(windowOpen), 32'd1);
    busWeN = 1'b1;
    @(negedge clk);
    expectExpiry((NS'(1) << 12) | (NS'(1) << 13), "R8");

    // R8 falling edge on the expiry edge
    prefix(); wr(16'h4000, 8'h30);
    repeat (TO - 1) @(negedge clk);
    busAddr = 16'h4800; busData = 8'hB0; busWeN = 1'b0;
    @(negedge clk);
    check(windowOpen && !eraseStart, "R8", {30'd0, windowOpen, eraseStart}, 32'd2);
    @(negedge clk); busWeN = 1'b1;
    @(negedge clk);
    expectExpiry(NS'(1) << 8, "R8");

    // random runs
    for (int it = 0; it < 40; it++) begin
      int k;
      bit abortRun;
      logic [AW-1:0] a;
      lastMask = eraseMask;
      k = 1 + int'($urandom % 5);
      abortRun = ($urandom % 5) == 0;
      a = AW'($urandom);
      prefix(); wr(a, 8'h30);
      expM = bitOf(a);
      for (int j = 1; j < k; j++) begin
        a = AW'($urandom);
        if ($urandom % 4 == 0) wr(a, 8'hB0);
        else begin wr(a, 8'h30); expM |= bitOf(a); end
      end
      if (abortRun) begin
        logic [7:0] bad;
        bad = 8'($urandom);
        if (bad == 8'h30 || bad == 8'hB0) bad = 8'h00;
        wr(AW'($urandom), bad);
        check(!windowOpen, "R10", 32'(windowOpen), 32'd0);
        quiet(TO + 2, "R10");
        check(eraseMask == lastMask, "R10", 32'(eraseMask), 32'(lastMask));
      end else begin
        expectExpiry(expM, "R7");
      end
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", nCheck - nFail, nCheck);
    $finish;
  end

endmodule